// File: doc/BRIEF.md
# PCM Receive Serial Port

This block receives one 8-bit companded voice sample per frame from a serial time-division highway. It is clocked by a fast system clock, and the highway's bit clock, frame sync and data arrive as sampled inputs. A frame begins at a bit-clock falling edge where the frame sync is seen high after being low at the previous falling edge. From that edge on, the port shifts data bits in most significant bit first. When all bits are in, it presents the assembled word on a parallel output together with a one-cycle valid pulse.

Two timing variants are selected by a mode input. In fixed rate mode the sync pulse is a short marker. Its width, counted in bit-clock falling edges, tells a normal frame from a signaling frame. After a signaling frame, the last received bit is held on a dedicated signaling output. In variable rate mode the sync acts as a timeslot enable. Bits are taken only while it stays high, and one word is delivered per high period. If the slot ends early, the partial word is discarded. An enable input carries the power-down and standby decisions made elsewhere in the chip. While it is low, capture stops and the signaling output is held low.

Top module: `pcmrx_port`

## Requirements
- R1: Bits are taken at falling edges of `bclk` (a sample where `bclk` is 0 and was 1 one clock earlier). The first bit is taken at the falling edge where `fsync` is high after being low at the previous falling edge. Bits fill `word` most significant bit first, so the first bit ends in `word[7]` and the eighth in `word[0]`.
- R2: In fixed rate mode (`var_mode`=0), the frame takes the starting falling edge and the next seven, whatever `fsync` does after the start. `word` changes and `word_valid` pulses high for exactly one clock only after the eighth bit, with exactly one pulse per frame.
- R3: In fixed rate mode, a sync that is high at the starting falling edge and at the next one (width 2 or more) marks a signaling frame. After that frame, `sig_bit` equals the eighth received bit (`word[0]`).
- R4: In fixed rate mode, a sync that is high only at the starting falling edge marks a normal frame, and `sig_bit` keeps its value.
- R5: After reset, `sig_bit` is 0 and stays 0 until the first signaling frame updates it. `word` resets to 0 and `word_valid` to 0.
- R6: In variable rate mode (`var_mode`=1), bits are taken at consecutive falling edges while `fsync` is high, and one word is delivered per high period of `fsync`. Further falling edges in the same high period produce no word.
- R7: Signaling frames are not recognised in variable rate mode: `sig_bit` keeps its value whatever the sync width.
- R8: In variable rate mode, if `fsync` is seen low at a falling edge before eight bits are in, the partial word is discarded: no pulse, and `word` is unchanged.
- R9: While `en` is low, `sig_bit` is 0 one clock later and no bits are captured. A frame in progress is dropped. A new frame needs a fresh low-to-high `fsync` seen with `en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable; low suspends capture and clears the signaling output |
| var_mode | input | 1 | 0 selects fixed rate mode, 1 selects variable rate mode |
| fsync | input | 1 | Receive frame sync or timeslot enable |
| bclk | input | 1 | Receive bit clock, sampled on `clk` |
| sdata | input | 1 | Serial PCM data |
| word | output | 8 | Last complete received word |
| word_valid | output | 1 | One-clock pulse when `word` is updated |
| sig_bit | output | 1 | Eighth bit of the most recent signaling frame |

## Verification
A bit counter that is off by one shows up as a missing or extra `word_valid` pulse and a word shifted by one bit. The bench catches this at the first frame after the fault, one clock after the eighth falling edge. A wrong sync-width classification shows as `sig_bit` taking or failing to take the last bit, visible as soon as that frame's word is presented. Stale frame state left behind by an abort or by a drop of `en` shows in the next frame as a spurious pulse or a corrupted word. The sweeps of all 256 words in both modes expose every bit position and both values of the signaling bit.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_CAPT = 1'b1} rx_state_t;

  function automatic logic sync_is_sig(input int unsigned run_len,
                                       input int unsigned thresh);
    return run_len >= thresh;
  endfunction

  function automatic int unsigned sat_inc(input int unsigned v,
                                          input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction
endpackage

// File: rtl/pcmrx_edge.sv
module pcmrx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fsync,
  output logic fall,
  output logic fs_prev
);
  logic bclk_q;

  assign fall = bclk_q & ~bclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      fs_prev <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (fall) fs_prev <= fsync;
    end
  end
endmodule

// File: rtl/pcmrx_framer.sv
module pcmrx_framer
  import pcmrx_pkg::*;
#(
  parameter int unsigned WORD_W     = 8,
  parameter int unsigned SIG_SYNC_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic var_mode,
  input  logic fsync,
  input  logic fall,
  input  logic fs_prev,
  output logic cap,
  output logic last,
  output logic sig_upd,
  output logic frame_var,
  output logic busy
);
  localparam int unsigned CNT_W  = $clog2(WORD_W);
  localparam int unsigned SLEN_W = $clog2(SIG_SYNC_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  rx_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic [SLEN_W-1:0] slen;
  logic             run_q, sig_q, mode_q;
  logic             start, abort, cont, sig_hit;

  assign busy      = (state == ST_CAPT);
  assign frame_var = mode_q;
  assign start     = en & fall & fsync & ~fs_prev & ~busy;
  assign abort     = busy & fall & mode_q & ~fsync;
  assign cont      = en & busy & fall & ~abort;
  assign cap       = start | cont;
  assign last      = cont & (cnt == LAST_IDX);
  assign sig_hit   = cont & ~mode_q & run_q & fsync &
                     sync_is_sig(int'(slen) + 1, SIG_SYNC_W);
  assign sig_upd   = last & ~mode_q & (sig_q | sig_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      slen   <= '0;
      run_q  <= 1'b0;
      sig_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (!en) begin
      state <= ST_IDLE;
      cnt   <= '0;
      run_q <= 1'b0;
      sig_q <= 1'b0;
    end else if (start) begin
      state  <= ST_CAPT;
      cnt    <= CNT_W'(1);
      mode_q <= var_mode;
      run_q  <= 1'b1;
      slen   <= SLEN_W'(1);
      sig_q  <= ~var_mode & sync_is_sig(1, SIG_SYNC_W);
    end else if (abort) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (cont) begin
      cnt   <= last ? '0 : cnt + 1'b1;
      state <= last ? ST_IDLE : ST_CAPT;
      run_q <= run_q & fsync;
      if (run_q & fsync) slen <= SLEN_W'(sat_inc(int'(slen), SIG_SYNC_W));
      sig_q <= sig_q | sig_hit;
    end
  end
endmodule

// File: rtl/pcmrx_shifter.sv
module pcmrx_shifter #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic              last,
  input  logic              sdata,
  output logic [WORD_W-1:0] word,
  output logic              word_valid
);
  logic [WORD_W-1:0] sh;

  function automatic logic [WORD_W-1:0] push_lsb(input logic [WORD_W-1:0] v,
                                                 input logic b);
    return {v[WORD_W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '0;
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= last;
      if (cap)  sh   <= push_lsb(sh, sdata);
      if (last) word <= push_lsb(sh, sdata);
    end
  end
endmodule

// File: rtl/pcmrx_siglatch.sv
module pcmrx_siglatch (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sig_upd,
  input  logic sdata,
  output logic sig_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sig_bit <= 1'b0;
    else if (!en)     sig_bit <= 1'b0;
    else if (sig_upd) sig_bit <= sdata;
  end
endmodule

// File: rtl/pcmrx_port.sv
module pcmrx_port #(
  parameter int unsigned WORD_W     = 8,
  parameter int unsigned SIG_SYNC_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              var_mode,
  input  logic              fsync,
  input  logic              bclk,
  input  logic              sdata,
  output logic [WORD_W-1:0] word,
  output logic              word_valid,
  output logic              sig_bit
);
  logic fall_evt, fs_prev, cap_evt, last_evt, sig_upd, frame_var, busy;

  pcmrx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .fall(fall_evt), .fs_prev(fs_prev)
  );

  pcmrx_framer #(.WORD_W(WORD_W), .SIG_SYNC_W(SIG_SYNC_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .en(en), .var_mode(var_mode), .fsync(fsync),
    .fall(fall_evt), .fs_prev(fs_prev), .cap(cap_evt), .last(last_evt),
    .sig_upd(sig_upd), .frame_var(frame_var), .busy(busy)
  );

  pcmrx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cap(cap_evt), .last(last_evt),
    .sdata(sdata), .word(word), .word_valid(word_valid)
  );

  pcmrx_siglatch u_sig (
    .clk(clk), .rst_n(rst_n), .en(en), .sig_upd(sig_upd),
    .sdata(sdata), .sig_bit(sig_bit)
  );
endmodule

// File: rtl/pcmrx_port_chk.sv
module pcmrx_port_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic fall_evt,
  input logic last_evt,
  input logic sig_upd,
  input logic frame_var,
  input logic word_valid,
  input logic sig_bit
);
  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  p_valid_after_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |-> fall_evt);

  p_sig_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sig_bit);

  p_sig_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !sig_upd) |=> $stable(sig_bit));

  p_no_var_sig_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sig_upd |-> !frame_var);

  p_sig_with_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sig_upd |=> word_valid);
endmodule

bind pcmrx_port pcmrx_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .fall_evt(fall_evt),
  .last_evt(last_evt), .sig_upd(sig_upd), .frame_var(frame_var),
  .word_valid(word_valid), .sig_bit(sig_bit)
);

// File: tb/pcmrx_port_test.sv
module pcmrx_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, var_mode = 1'b0, fsync = 1'b0, bclk = 1'b1, sdata = 1'b0;
  logic [7:0] word;
  logic       word_valid, sig_bit;

  int checks = 0, fails = 0, pulses = 0;
  logic [7:0] seen_word = 8'h00;
  logic exp_sig = 1'b0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  pcmrx_port uut (
    .clk(clk), .rst_n(rst_n), .en(en), .var_mode(var_mode), .fsync(fsync),
    .bclk(bclk), .sdata(sdata), .word(word), .word_valid(word_valid),
    .sig_bit(sig_bit)
  );

  always @(negedge clk) if (word_valid) begin
    pulses++;
    seen_word = word;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_cyc(input logic fs, input logic d);
    @(negedge clk);
    bclk = 1'b0; fsync = fs; sdata = d;
    @(negedge clk);
    bclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic frame_fixed(input logic [7:0] w, input int sw);
    bit_cyc(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) bit_cyc(i < sw, w[7-i]);
    bit_cyc(1'b0, 1'b0);
  endtask

  task automatic frame_var(input logic [7:0] w, input int extra);
    bit_cyc(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) bit_cyc(1'b1, w[7-i]);
    for (int i = 0; i < extra; i++) bit_cyc(1'b1, ~w[i]);
    bit_cyc(1'b0, 1'b0);
  endtask

  task automatic check_frame(input int p0, input logic [7:0] w, input string tag);
    chk(pulses == p0 + 1, {tag, " pulse count"}, pulses - p0, 1);
    chk(seen_word == w, {tag, " word"}, seen_word, w);
    chk(word == w, {tag, " word held"}, word, w);
    chk(sig_bit == exp_sig, {tag, " sig_bit"}, sig_bit, exp_sig);
  endtask

  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    chk(word == 8'h00 && word_valid == 1'b0, "R5 reset word/valid", word, 0);
    chk(sig_bit == 1'b0, "R5 reset sig_bit", sig_bit, 0);
    rst_n = 1'b1; en = 1'b1;

    // R1 R2 R4 R5: fixed mode normal frames, every word, sig stays low
    for (int w = 0; w < 256; w++) begin
      p0 = pulses;
      frame_fixed(8'(w), 1);
      check_frame(p0, 8'(w), "R1 R2 R4 R5 fixed normal");
    end

    // R3: signaling frames, widths 2 and 3
    for (int w = 0; w < 256; w += 7) begin
      p0 = pulses;
      exp_sig = w[0];
      frame_fixed(8'(w), (w % 2 == 0) ? 2 : 3);
      check_frame(p0, 8'(w), "R3 fixed signaling");
    end

    // R4: normal frame keeps the latched bit
    p0 = pulses; exp_sig = 1'b1;
    frame_fixed(8'h81, 2);
    check_frame(p0, 8'h81, "R3 set sig");
    p0 = pulses;
    frame_fixed(8'h40, 1);
    check_frame(p0, 8'h40, "R4 normal keeps sig");

    // R6 R7: variable mode, extra falls in the same slot, no signaling
    var_mode = 1'b1;
    for (int w = 0; w < 256; w++) begin
      p0 = pulses;
      frame_var(8'(w), w % 4);
      check_frame(p0, 8'(w), "R6 R7 variable");
    end

    // R8: early end of slot discards the partial word
    for (int k = 1; k < 8; k++) begin
      p0 = pulses;
      bit_cyc(1'b0, 1'b0);
      for (int i = 0; i < k; i++) bit_cyc(1'b1, 1'b1);
      bit_cyc(1'b0, 1'b0);
      chk(pulses == p0, "R8 abort no pulse", pulses - p0, 0);
      chk(word == 8'hff, "R8 abort word unchanged", word, 8'hff);
      p0 = pulses;
      frame_var(8'h5a + 8'(k), 0);
      check_frame(p0, 8'h5a + 8'(k), "R8 frame after abort");
      frame_var(8'hff, 0);
    end

    // R9: enable low clears sig, blocks capture, drops a frame in progress
    var_mode = 1'b0;
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk(sig_bit == 1'b0, "R9 sig cleared", sig_bit, 0);
    exp_sig = 1'b0;
    p0 = pulses;
    frame_fixed(8'h3c, 2);
    chk(pulses == p0, "R9 no capture while disabled", pulses - p0, 0);
    chk(sig_bit == 1'b0, "R9 sig stays low", sig_bit, 0);
    en = 1'b1;
    p0 = pulses;
    bit_cyc(1'b0, 1'b0);
    bit_cyc(1'b1, 1'b1);
    bit_cyc(1'b1, 1'b0);
    bit_cyc(1'b0, 1'b1);
    @(negedge clk); en = 1'b0;
    for (int i = 0; i < 5; i++) bit_cyc(1'b0, 1'b1);
    @(negedge clk); en = 1'b1;
    for (int i = 0; i < 8; i++) bit_cyc(1'b0, 1'b1);
    chk(pulses == p0, "R9 frame dropped", pulses - p0, 0);
    chk(sig_bit == 1'b0, "R9 dropped signaling frame", sig_bit, 0);
    p0 = pulses; exp_sig = 1'b1;
    frame_fixed(8'hc3, 2);
    check_frame(p0, 8'hc3, "R9 frame after enable");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule